// File: doc/BRIEF.md
# Vector Logic, Arithmetic and Shift Sequencer

This block executes one register-to-register vector instruction at a time against an external register file of 128 entries, each 32 bits wide. A 32-bit instruction word names an operation group, an element count, an operation code, two source registers and a destination register. The sequencer then steps through the elements, one per clock. For each element it reads A[i], forms the second operand from B[i], from a scalar register or from a sign-extended 7-bit immediate, and writes the result to the next destination register in the run.

Instructions enter through a valid/ready handshake. The register file is reached through two combinational read ports and one write port. Operations that need a scalar value (scalar logic and arithmetic forms, the running sum and the funnel shift by register) spend one extra cycle fetching that scalar before the element loop starts. Every register address that is read as zero comes back as zero, whatever the register file holds in that entry. The controller is a three-state machine:

- **IDLE**: the block is ready for an instruction.
- **SCALAR**: the scalar operand is fetched and held.
- **RUN**: one element is processed per cycle.

The transitions are:

- *accept-drop*: IDLE to IDLE, taken for an unsupported group.
- *accept-scalar*: IDLE to SCALAR.
- *accept-run*: IDLE to RUN.
- *scalar-done*: SCALAR to RUN.
- *step*: RUN to RUN.
- *last*: RUN to IDLE, on the final element.

Top module: `vec_alu_seq`

## Requirements
- R1: After reset the block is in IDLE with `instr_ready` high, and it drives no register write while `instr_ready` is high.
- R2: Bits 31:28 select the group: 0xA arithmetic, 0xB logic, 0xC shift. Any other group value is accepted and dropped: no register is written, and `instr_ready` is high again on the next cycle.
- R3: Field positions are: count in bits 27:24, operation in bits 23:21, source A in bits 20:14, destination in bits 13:7, and source B or immediate in bits 6:0. The run has count+1 elements. Source, destination and next-source indices advance by one per element and wrap modulo 128.
- R4: Logic operation codes are: 0 A AND B[i], 1 A AND scalar, 2 A AND immediate, 3 A XOR B[i], 4 A XOR scalar, 5 A XOR immediate, 6 A OR B[i], 7 A OR scalar.
- R5: Arithmetic operation codes are: 0 A+B[i], 1 A+scalar, 2 A+immediate, 4 A-B[i], 5 A-scalar, 6 A-immediate. The immediate is the 7-bit field sign-extended to 32 bits.
- R6: Arithmetic code 3 (sum) starts from the value of register B, adds A[i] over the whole run, and writes only the destination register.
- R7: Arithmetic code 7 (abs) writes A[i]-B[i] when B[i] is negative and A[i]+B[i] otherwise.
- R8: Shift codes 0/1 are logical right, 2/3 arithmetic right and 4/5 left; even codes take the amount from B[i] and odd codes from the immediate. Only the low 5 bits of the amount are used.
- R9: Shift codes 6 and 7 are a funnel left: A[i] joined above A[i+1], shifted left, upper 32 bits kept. The amount comes from the scalar in register B (code 6) or from the immediate (code 7); an amount of 0 yields A[i].
- R10: A read of register 0 yields zero on every operand path.
- R11: An accepted instruction keeps `instr_ready` low for count+1 cycles, plus one cycle when a scalar is needed (arithmetic 1, 3, 5; logic 1, 4, 7; shift 6). Valid is ignored while `instr_ready` is low.
- R12: Element i reads its operands after the result of element i-1 has been written, so runs whose destination overlaps a later source see the updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is offered |
| instr_ready | output | 1 | Block is idle and takes the offered word |
| instr | input | 32 | Instruction word |
| rf_ra_addr | output | 7 | Register file read address, port A |
| rf_ra_data | input | 32 | Read data for port A, same cycle |
| rf_rb_addr | output | 7 | Register file read address, port B |
| rf_rb_data | input | 32 | Read data for port B, same cycle |
| rf_we | output | 1 | Register write enable |
| rf_wa | output | 7 | Register write address |
| rf_wd | output | 32 | Register write data |

## Verification
The assertions assume the following about the inputs:

- The register file answers both read ports in the same cycle the address is presented.
- The group nibble of an offered word is never unknown.
- Reset is held long enough for the first sampled cycle to be IDLE.

The stimulus keeps within these assumptions. The bench register file decodes its read addresses combinationally from its array. Words are applied only between clock edges, and valid is dropped after the accepting edge. The register file is loaded through a side path only while the block sits in IDLE.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int INSTR_W = 32;
    localparam int RADDR_W = 7;
    localparam int CNT_W   = 4;
    localparam int OP_W    = 3;
    localparam int IMM_W   = 7;
    localparam int GRP_W   = 4;

    // field positions inside the instruction word
    localparam int GRP_LSB = 28;
    localparam int CNT_LSB = 24;
    localparam int OP_LSB  = 21;
    localparam int SA_LSB  = 14;
    localparam int SD_LSB  = 7;
    localparam int SB_LSB  = 0;

    localparam logic [GRP_W-1:0] GRP_ARITH = 4'hA;
    localparam logic [GRP_W-1:0] GRP_LOGIC = 4'hB;
    localparam logic [GRP_W-1:0] GRP_SHIFT = 4'hC;

    typedef enum logic [3:0] {
        FN_AND, FN_XOR, FN_OR, FN_ADD, FN_SUB, FN_ABS,
        FN_SRL, FN_SRA, FN_SLL, FN_FUNNEL
    } fn_e;

    typedef enum logic [1:0] {
        BS_VEC,   // second operand is B[i]
        BS_SCAL,  // held scalar
        BS_IMM,   // sign-extended immediate
        BS_ACC    // running accumulator
    } bsel_e;

    typedef struct packed {
        logic  legal;
        fn_e   fn;
        bsel_e bsel;
        logic  next_a;       // port B reads A[i+1]
        logic  need_scalar;
        logic  is_sum;
    } ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCALAR,
        ST_RUN
    } st_e;
endpackage

// File: rtl/vseq_decode.sv
module vseq_decode
    import vseq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctl_t               ctl,
    output logic [RADDR_W-1:0] src_a,
    output logic [RADDR_W-1:0] dst,
    output logic [RADDR_W-1:0] src_b,
    output logic [CNT_W-1:0]   cnt_m1
);
    logic [GRP_W-1:0] grp;
    logic [OP_W-1:0]  op;

    assign grp    = instr[GRP_LSB +: GRP_W];
    assign op     = instr[OP_LSB +: OP_W];
    assign cnt_m1 = instr[CNT_LSB +: CNT_W];
    assign src_a  = instr[SA_LSB +: RADDR_W];
    assign dst    = instr[SD_LSB +: RADDR_W];
    assign src_b  = instr[SB_LSB +: RADDR_W];

    always_comb begin
        ctl = '{legal: 1'b1, fn: FN_AND, bsel: BS_VEC, next_a: 1'b0,
                need_scalar: 1'b0, is_sum: 1'b0};
        case (grp)
            GRP_LOGIC: begin
                unique case (op)
                    3'd0: begin ctl.fn = FN_AND; ctl.bsel = BS_VEC;  end
                    3'd1: begin ctl.fn = FN_AND; ctl.bsel = BS_SCAL; end
                    3'd2: begin ctl.fn = FN_AND; ctl.bsel = BS_IMM;  end
                    3'd3: begin ctl.fn = FN_XOR; ctl.bsel = BS_VEC;  end
                    3'd4: begin ctl.fn = FN_XOR; ctl.bsel = BS_SCAL; end
                    3'd5: begin ctl.fn = FN_XOR; ctl.bsel = BS_IMM;  end
                    3'd6: begin ctl.fn = FN_OR;  ctl.bsel = BS_VEC;  end
                    3'd7: begin ctl.fn = FN_OR;  ctl.bsel = BS_SCAL; end
                endcase
            end
            GRP_ARITH: begin
                unique case (op)
                    3'd0: begin ctl.fn = FN_ADD; ctl.bsel = BS_VEC;  end
                    3'd1: begin ctl.fn = FN_ADD; ctl.bsel = BS_SCAL; end
                    3'd2: begin ctl.fn = FN_ADD; ctl.bsel = BS_IMM;  end
                    3'd3: begin ctl.fn = FN_ADD; ctl.bsel = BS_ACC;  end
                    3'd4: begin ctl.fn = FN_SUB; ctl.bsel = BS_VEC;  end
                    3'd5: begin ctl.fn = FN_SUB; ctl.bsel = BS_SCAL; end
                    3'd6: begin ctl.fn = FN_SUB; ctl.bsel = BS_IMM;  end
                    3'd7: begin ctl.fn = FN_ABS; ctl.bsel = BS_VEC;  end
                endcase
            end
            GRP_SHIFT: begin
                unique case (op)
                    3'd0: begin ctl.fn = FN_SRL; ctl.bsel = BS_VEC; end
                    3'd1: begin ctl.fn = FN_SRL; ctl.bsel = BS_IMM; end
                    3'd2: begin ctl.fn = FN_SRA; ctl.bsel = BS_VEC; end
                    3'd3: begin ctl.fn = FN_SRA; ctl.bsel = BS_IMM; end
                    3'd4: begin ctl.fn = FN_SLL; ctl.bsel = BS_VEC; end
                    3'd5: begin ctl.fn = FN_SLL; ctl.bsel = BS_IMM; end
                    3'd6: begin
                        ctl.fn = FN_FUNNEL; ctl.bsel = BS_SCAL; ctl.next_a = 1'b1;
                    end
                    3'd7: begin
                        ctl.fn = FN_FUNNEL; ctl.bsel = BS_IMM; ctl.next_a = 1'b1;
                    end
                endcase
            end
            default: ctl.legal = 1'b0;
        endcase
        ctl.is_sum      = (ctl.bsel == BS_ACC);
        ctl.need_scalar = ctl.legal && ((ctl.bsel == BS_SCAL) || (ctl.bsel == BS_ACC));
    end
endmodule

// File: rtl/vseq_alu.sv
module vseq_alu
    import vseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fn_e               fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] nxt,
    output logic [DATA_W-1:0] res
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   amt;
    logic [DATA_W-1:0] funnel;

    assign amt    = opb[SH_W-1:0];
    assign funnel = (amt == '0) ? opa
                  : ((opa << amt) | (nxt >> (DATA_W - int'(amt))));

    always_comb begin
        unique case (fn)
            FN_AND:    res = opa & opb;
            FN_XOR:    res = opa ^ opb;
            FN_OR:     res = opa | opb;
            FN_ADD:    res = opa + opb;
            FN_SUB:    res = opa - opb;
            FN_ABS:    res = opb[DATA_W-1] ? (opa - opb) : (opa + opb);
            FN_SRL:    res = opa >> amt;
            FN_SRA:    res = DATA_W'($signed(opa) >>> amt);
            FN_SLL:    res = opa << amt;
            FN_FUNNEL: res = funnel;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/vseq_agen.sv
module vseq_agen
    import vseq_pkg::*;
(
    input  logic               st_run,
    input  logic               st_scalar,
    input  logic               next_a,
    input  logic               is_sum,
    input  logic [RADDR_W-1:0] base_a,
    input  logic [RADDR_W-1:0] base_b,
    input  logic [RADDR_W-1:0] base_d,
    input  logic [CNT_W-1:0]   idx,
    output logic [RADDR_W-1:0] ra,
    output logic [RADDR_W-1:0] rb,
    output logic [RADDR_W-1:0] wa
);
    logic [RADDR_W-1:0] off;
    logic [RADDR_W-1:0] a_cur;

    // modulo-128 arithmetic falls out of the address width
    assign off   = RADDR_W'(idx);
    assign a_cur = base_a + off;

    always_comb begin
        ra = st_run ? a_cur : '0;
        if (st_scalar)
            rb = base_b;
        else if (st_run)
            rb = next_a ? (a_cur + RADDR_W'(1)) : (base_b + off);
        else
            rb = '0;
        wa = is_sum ? base_d : (base_d + off);
    end
endmodule

// File: rtl/vec_alu_seq.sv
module vec_alu_seq
    import vseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    output logic               instr_ready,
    input  logic [INSTR_W-1:0] instr,
    output logic [RADDR_W-1:0] rf_ra_addr,
    input  logic [DATA_W-1:0]  rf_ra_data,
    output logic [RADDR_W-1:0] rf_rb_addr,
    input  logic [DATA_W-1:0]  rf_rb_data,
    output logic               rf_we,
    output logic [RADDR_W-1:0] rf_wa,
    output logic [DATA_W-1:0]  rf_wd
);
    localparam int EXT_W = DATA_W - IMM_W;

    st_e                state_q, state_d;
    ctl_t               dec_ctl, ctl_q;
    logic [RADDR_W-1:0] dec_sa, dec_sd, dec_sb;
    logic [CNT_W-1:0]   dec_cnt;
    logic [RADDR_W-1:0] sa_q, sd_q, sb_q;
    logic [CNT_W-1:0]   cnt_q, idx_q;
    logic [DATA_W-1:0]  held_q;
    logic [DATA_W-1:0]  a_val, b_raw, b_op, imm_ext, alu_y;
    logic               accept, last;

    vseq_decode u_dec (
        .instr  (instr),
        .ctl    (dec_ctl),
        .src_a  (dec_sa),
        .dst    (dec_sd),
        .src_b  (dec_sb),
        .cnt_m1 (dec_cnt)
    );

    vseq_agen u_agen (
        .st_run    (state_q == ST_RUN),
        .st_scalar (state_q == ST_SCALAR),
        .next_a    (ctl_q.next_a),
        .is_sum    (ctl_q.is_sum),
        .base_a    (sa_q),
        .base_b    (sb_q),
        .base_d    (sd_q),
        .idx       (idx_q),
        .ra        (rf_ra_addr),
        .rb        (rf_rb_addr),
        .wa        (rf_wa)
    );

    vseq_alu #(.DATA_W(DATA_W)) u_alu (
        .fn  (ctl_q.fn),
        .opa (a_val),
        .opb (b_op),
        .nxt (b_raw),
        .res (alu_y)
    );

    assign accept  = (state_q == ST_IDLE) && instr_valid;
    assign last    = (idx_q == cnt_q);
    assign imm_ext = {{EXT_W{sb_q[IMM_W-1]}}, sb_q[IMM_W-1:0]};

    // register zero reads as zero on both ports
    assign a_val = (rf_ra_addr == '0) ? '0 : rf_ra_data;
    assign b_raw = (rf_rb_addr == '0) ? '0 : rf_rb_data;

    always_comb begin
        unique case (ctl_q.bsel)
            BS_VEC:  b_op = b_raw;
            BS_SCAL: b_op = held_q;
            BS_IMM:  b_op = imm_ext;
            BS_ACC:  b_op = held_q;
            default: b_op = b_raw;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!dec_ctl.legal)
                        state_d = ST_IDLE;      // accept-drop
                    else if (dec_ctl.need_scalar)
                        state_d = ST_SCALAR;    // accept-scalar
                    else
                        state_d = ST_RUN;       // accept-run
                end
            end
            ST_SCALAR: state_d = ST_RUN;        // scalar-done
            ST_RUN:    state_d = last ? ST_IDLE : ST_RUN;  // last / step
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        instr_ready = 1'b0;
        rf_we       = 1'b0;
        rf_wd       = alu_y;
        unique case (state_q)
            ST_IDLE:   instr_ready = 1'b1;
            ST_SCALAR: rf_we = 1'b0;
            ST_RUN:    rf_we = !ctl_q.is_sum || last;
            default:   instr_ready = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            sa_q   <= '0;
            sd_q   <= '0;
            sb_q   <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            held_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        ctl_q <= dec_ctl;
                        sa_q  <= dec_sa;
                        sd_q  <= dec_sd;
                        sb_q  <= dec_sb;
                        cnt_q <= dec_cnt;
                        idx_q <= '0;
                    end
                end
                ST_SCALAR: held_q <= b_raw;
                ST_RUN: begin
                    idx_q <= idx_q + 1'b1;
                    if (ctl_q.is_sum)
                        held_q <= alu_y;
                end
                default: idx_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/vec_alu_seq_chk.sv
module vec_alu_seq_chk #(
    parameter int CNT_W   = 4,
    parameter int RADDR_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic               instr_ready,
    input logic [3:0]         instr_grp,
    input logic               rf_we,
    input logic [RADDR_W-1:0] rf_wa
);
    localparam int MAX_BUSY = (1 << CNT_W) + 1;

    logic [CNT_W+1:0] busy_q;
    logic             grp_ok;

    assign grp_ok = (instr_grp == 4'hA) || (instr_grp == 4'hB) || (instr_grp == 4'hC);

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= '0;
        else if (instr_ready)
            busy_q <= '0;
        else
            busy_q <= busy_q + 1'b1;
    end

    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> !rf_we);

    a_r3_dest_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(rf_we)) |-> (rf_wa == RADDR_W'($past(rf_wa) + 1'b1)));

    a_r2_unsupported_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && !grp_ok) |=> instr_ready);

    a_r11_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && grp_ok) |=> !instr_ready);

    a_r11_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |-> (busy_q < MAX_BUSY));
endmodule

bind vec_alu_seq vec_alu_seq_chk #(
    .CNT_W   (vseq_pkg::CNT_W),
    .RADDR_W (vseq_pkg::RADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_grp   (instr[31:28]),
    .rf_we       (rf_we),
    .rf_wa       (rf_wa)
);

// File: tb/vec_alu_seq_tb_top.sv
module vec_alu_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic        instr_ready;
    logic [31:0] instr;
    logic [6:0]  rf_ra_addr, rf_rb_addr, rf_wa;
    logic [31:0] rf_ra_data, rf_rb_data, rf_wd;
    logic        rf_we;

    logic        ld_en;
    logic [6:0]  ld_addr;
    logic [31:0] ld_data;

    logic [31:0] rf  [128];
    logic [31:0] mdl [128];

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vec_alu_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_ready (instr_ready),
        .instr       (instr),
        .rf_ra_addr  (rf_ra_addr),
        .rf_ra_data  (rf_ra_data),
        .rf_rb_addr  (rf_rb_addr),
        .rf_rb_data  (rf_rb_data),
        .rf_we       (rf_we),
        .rf_wa       (rf_wa),
        .rf_wd       (rf_wd)
    );

    always_ff @(posedge clk) begin
        if (ld_en)
            rf[ld_addr] <= ld_data;
        else if (rf_we)
            rf[rf_wa] <= rf_wd;
    end
    assign rf_ra_data = rf[rf_ra_addr];
    assign rf_rb_data = rf[rf_rb_addr];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [6:0] r);
        return (r == 7'd0) ? 32'd0 : mdl[r];
    endfunction

    function automatic bit needs_scalar(input logic [3:0] g, input logic [2:0] op);
        return (g == 4'hA && (op == 3'd1 || op == 3'd3 || op == 3'd5)) ||
               (g == 4'hB && (op == 3'd1 || op == 3'd4 || op == 3'd7)) ||
               (g == 4'hC && op == 3'd6);
    endfunction

    function automatic logic [31:0] elem(input logic [3:0] g, input logic [2:0] op,
        input logic [31:0] a, input logic [31:0] bv, input logic [31:0] s,
        input logic [6:0] imm, input logic [31:0] nx);
        logic [31:0] ix;
        logic [63:0] cat;
        int          sh;
        ix = {{25{imm[6]}}, imm};
        if (g == 4'hB) begin
            case (op)
                3'd0: return a & bv;
                3'd1: return a & s;
                3'd2: return a & ix;
                3'd3: return a ^ bv;
                3'd4: return a ^ s;
                3'd5: return a ^ ix;
                3'd6: return a | bv;
                default: return a | s;
            endcase
        end else if (g == 4'hA) begin
            case (op)
                3'd0: return a + bv;
                3'd1: return a + s;
                3'd2: return a + ix;
                3'd4: return a - bv;
                3'd5: return a - s;
                3'd6: return a - ix;
                default: return ($signed(bv) < 0) ? a - bv : a + bv;
            endcase
        end else begin
            sh = (op[0] ? int'(imm[4:0]) : int'(bv[4:0]));
            case (op)
                3'd0, 3'd1: return a >> sh;
                3'd2, 3'd3: return 32'($signed(a) >>> sh);
                3'd4, 3'd5: return a << sh;
                default: begin
                    sh  = (op == 3'd6) ? int'(s[4:0]) : int'(imm[4:0]);
                    cat = {a, nx} << sh;
                    return cat[63:32];
                end
            endcase
        end
    endfunction

    // sequential reference: each element sees earlier elements' writes
    task automatic model_exec(input logic [31:0] w);
        logic [3:0]  g;
        logic [2:0]  op;
        logic [6:0]  sa, sd, sb;
        logic [31:0] s, acc;
        int          n;
        g  = w[31:28]; op = w[23:21];
        sa = w[20:14]; sd = w[13:7]; sb = w[6:0];
        n  = int'(w[27:24]) + 1;
        if (g != 4'hA && g != 4'hB && g != 4'hC) return;
        s = rd(sb);
        if (g == 4'hA && op == 3'd3) begin
            acc = s;
            for (int i = 0; i < n; i++) acc += rd(7'(sa + i));
            mdl[sd] = acc;
        end else begin
            for (int i = 0; i < n; i++)
                mdl[7'(sd + i)] = elem(g, op, rd(7'(sa + i)), rd(7'(sb + i)), s, sb,
                                       rd(7'(sa + i + 1)));
        end
    endtask

    task automatic fill();
        for (int r = 0; r < 128; r++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = 7'(r);
            ld_data = (r == 7) ? 32'h8000_0001 : $urandom;
            mdl[r]  = ld_data;
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_instr(input logic [31:0] w, input string tag);
        int  busy, exp_busy, bad;
        bit  legal;
        legal    = (w[31:28] == 4'hA) || (w[31:28] == 4'hB) || (w[31:28] == 4'hC);
        exp_busy = legal ? int'(w[27:24]) + 1 + (needs_scalar(w[31:28], w[23:21]) ? 1 : 0) : 0;
        model_exec(w);
        @(negedge clk);
        check(instr_ready == 1'b1, "R11", 32'(instr_ready), 32'd1);
        instr       = w;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        busy = 0;
        while (!instr_ready && busy < 100) begin
            busy++;
            @(negedge clk);
        end
        check(busy == exp_busy, "R11", 32'(busy), 32'(exp_busy));
        bad = -1;
        for (int r = 0; r < 128; r++)
            if (bad < 0 && rf[r] !== mdl[r]) bad = r;
        if (bad < 0) check(1'b1, tag, 32'd0, 32'd0);
        else begin
            $display("  word %h first mismatch at register %0d", w, bad);
            check(1'b0, tag, rf[bad], mdl[bad]);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] g, input logic [3:0] c,
        input logic [2:0] op, input logic [6:0] sa, input logic [6:0] sd, input logic [6:0] sb);
        return {g, c, op, sa, sd, sb};
    endfunction

    function automatic string tag_of(input logic [3:0] g, input logic [2:0] op);
        if (g == 4'hB) return "R4";
        if (g == 4'hA) return (op == 3'd3) ? "R6" : (op == 3'd7) ? "R7" : "R5";
        return (op >= 3'd6) ? "R9" : "R8";
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] grps [3];
        grps[0] = 4'hA; grps[1] = 4'hB; grps[2] = 4'hC;
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
        ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(instr_ready == 1'b1, "R1", 32'(instr_ready), 32'd1);
        check(rf_we == 1'b0, "R1", 32'(rf_we), 32'd0);

        // near-exhaustive sweep of every group/op pairing
        for (int gi = 0; gi < 3; gi++) begin
            fill();
            for (int op = 0; op < 8; op++)
                for (int t = 0; t < 6; t++)
                    run_instr(mk(grps[gi], 4'($urandom), 3'(op), 7'($urandom),
                                 7'($urandom), 7'($urandom)), tag_of(grps[gi], 3'(op)));
        end

        fill();
        // R2: unsupported groups change nothing and return at once
        run_instr(mk(4'h0, 4'd3, 3'd0, 7'd5, 7'd9, 7'd6), "R2");
        run_instr(mk(4'h5, 4'd15, 3'd2, 7'd1, 7'd2, 7'd3), "R2");
        run_instr(mk(4'hF, 4'd7, 3'd7, 7'd40, 7'd41, 7'd42), "R2");
        // R3: full-length run crossing the 127 -> 0 boundary on every index
        run_instr(mk(4'hB, 4'd15, 3'd3, 7'd126, 7'd125, 7'd120), "R3");
        run_instr(mk(4'hA, 4'd0, 3'd0, 7'd127, 7'd127, 7'd127), "R3");
        // R5: immediates at the sign boundary
        run_instr(mk(4'hA, 4'd4, 3'd6, 7'd10, 7'd50, 7'h40), "R5");
        run_instr(mk(4'hB, 4'd2, 3'd2, 7'd11, 7'd60, 7'h7F), "R5");
        run_instr(mk(4'hA, 4'd2, 3'd2, 7'd12, 7'd70, 7'h3F), "R5");
        // R6: sum seeded from register zero and from a live register
        run_instr(mk(4'hA, 4'd15, 3'd3, 7'd80, 7'd5, 7'd0), "R6");
        run_instr(mk(4'hA, 4'd0, 3'd3, 7'd81, 7'd6, 7'd90), "R6");
        // R7: abs of B with A taken from register zero
        run_instr(mk(4'hA, 4'd7, 3'd7, 7'd0, 7'd100, 7'd1), "R7");
        // R8: shift amounts 0 and 31 by immediate
        run_instr(mk(4'hC, 4'd1, 3'd3, 7'd7, 7'd20, 7'd31), "R8");
        run_instr(mk(4'hC, 4'd1, 3'd1, 7'd7, 7'd22, 7'd0), "R8");
        run_instr(mk(4'hC, 4'd1, 3'd5, 7'd7, 7'd24, 7'h7F), "R8");
        // R9: funnel by immediate 0 and 31, and by the scalar in register 7
        run_instr(mk(4'hC, 4'd3, 3'd7, 7'd40, 7'd110, 7'd0), "R9");
        run_instr(mk(4'hC, 4'd3, 3'd7, 7'd40, 7'd114, 7'd31), "R9");
        run_instr(mk(4'hC, 4'd3, 3'd6, 7'd44, 7'd118, 7'd7), "R9");
        // R10: register zero as A, as B and as scalar
        run_instr(mk(4'hA, 4'd2, 3'd0, 7'd0, 7'd30, 7'd60), "R10");
        run_instr(mk(4'hB, 4'd2, 3'd6, 7'd61, 7'd33, 7'd0), "R10");
        run_instr(mk(4'hB, 4'd2, 3'd7, 7'd62, 7'd36, 7'd0), "R10");
        // R12: destination one ahead of the source makes a chain
        run_instr(mk(4'hA, 4'd5, 3'd2, 7'd30, 7'd31, 7'd1), "R12");
        run_instr(mk(4'hC, 4'd4, 3'd7, 7'd50, 7'd51, 7'd4), "R12");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule